// File: doc/BRIEF.md
# Vectored Interrupt Controller with Masking

The controller collects fifteen edge-triggered interrupt sources for a small 8-bit processor core. A rising edge on a source input latches a pending bit. Software sees these bits, and a per-source enable for each, through four byte-wide registers on a simple read/write port. One bit of the low enable register is the global enable. Software may set or clear pending bits directly, and a set bit then raises an interrupt like any hardware edge.

At each instruction boundary the core asks whether to enter service. The controller answers in the same cycle. It names the winning source and gives the program address of that source's 16-bit vector entry. It also gives the stack pointer value the core uses for the three-byte frame: PC low on top, then PC high, then flags. On the clock edge that accepts the source, the controller clears that source's pending bit and the global enable. The core reports enable-interrupt, disable-interrupt and return-from-interrupt operations on separate strobes. The controller also gives the stack pointer value after the return pops that frame.

Top module: `irq_vector_ctl`

## Requirements
- R1: After reset every pending bit, every per-source enable and the global enable are 0. `take_o` stays low at a boundary.
- R2: Register map, decoded from `reg_addr_i`:
  - 0xFA: pending bits of sources 0..6 in bits 0..6. Bit 7 reads 0.
  - 0xFB: enables of sources 0..6 in bits 0..6, and the global enable in bit 7.
  - 0xF8: pending bits of sources 7..14 in bits 0..7.
  - 0xF9: enables of sources 7..14 in bits 0..7.
  - Every other address reads 0x00.
  - Reads are combinational. A write takes effect at the clock edge where `reg_we_i` is high.
- R3: A 0-to-1 transition of `irq_i[n]`, seen between two clock edges, sets pending bit n. A level held high does not set the bit again after software clears it.
- R4: A write to a pending register replaces its bits. A rising edge in the same cycle still sets its own bit.
- R5: `take_o` is high exactly when all three hold: `boundary_i` is high, the global enable is 1, and some source is both pending and enabled.
- R6: When `take_o` is high, `src_o` is the lowest-numbered pending and enabled source. `vector_o` equals 2 × `src_o`.
- R7: On the clock edge where `take_o` is high, the accepted source's pending bit is cleared and the global enable is cleared.
- R8: `ei_i` and `iret_i` set the global enable, and `di_i` clears it. An accepted interrupt overrides all three in the same cycle.
- R9: `sp_entry_o` equals `sp_i` − 3, and `sp_return_o` equals `sp_i` + 3, both modulo 2^16.
- R10: A source input already high when reset is released does not set its pending bit until it falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 15 | Interrupt source levels, rising edge requests |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| boundary_i | input | 1 | Core is at an instruction boundary |
| ei_i | input | 1 | Enable-interrupt operation |
| di_i | input | 1 | Disable-interrupt operation |
| iret_i | input | 1 | Return-from-interrupt operation |
| sp_i | input | 16 | Current stack pointer |
| take_o | output | 1 | Enter service now |
| src_o | output | 4 | Accepted source number |
| vector_o | output | 16 | Program address of the vector entry |
| sp_entry_o | output | 16 | Stack pointer after pushing the frame |
| sp_return_o | output | 16 | Stack pointer after popping the frame |

## Verification
The bench holds a source input high through reset. A design whose edge detector resets its history low would report a spurious request there.

It writes the low pending register in the same cycle as a hardware edge. A design that lets the write win would lose that request.

With two sources pending, it masks the lower one and then unmasks it. This catches inverted priority and stale vector addresses. It also reads back the pending and global-enable bits after each acceptance, so a design that keeps the global enable or clears the wrong pending bit would nest or repeat service.

// File: rtl/icu_pkg.sv
package icu_pkg;
    localparam int SRC_N = 15;
    localparam int LO_N  = 7;
    localparam int HI_N  = SRC_N - LO_N;
    localparam int IDW   = $clog2(SRC_N);

    typedef struct packed {
        logic             gie;
        logic [SRC_N-1:0] en;
        logic [SRC_N-1:0] req;
    } icu_state_t;
endpackage

// File: rtl/icu_edge.sv
module icu_edge #(
    parameter int N = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    // History resets high so a level present at reset is not an edge (R10)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/icu_prio.sv
module icu_prio #(
    parameter int N   = 15,
    parameter int IDW = 4
) (
    input  logic [N-1:0]   pend_i,
    output logic           any_o,
    output logic [N-1:0]   sel_oh_o,
    output logic [IDW-1:0] idx_o
);
    logic [N:0] lower;
    assign lower[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chain
            assign lower[g+1]   = lower[g] | pend_i[g];
            assign sel_oh_o[g]  = pend_i[g] & ~lower[g];
        end
    endgenerate

    assign any_o = lower[N];

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = IDW'(i);
        end
    end
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
    import icu_pkg::*;
#(
    parameter int          AW        = 8,
    parameter int          SPW       = 16,
    parameter int          FRAME_B   = 3,
    parameter logic [AW-1:0] A_REQ_LO = 8'hFA,
    parameter logic [AW-1:0] A_MSK_LO = 8'hFB,
    parameter logic [AW-1:0] A_REQ_HI = 8'hF8,
    parameter logic [AW-1:0] A_MSK_HI = 8'hF9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] irq_i,
    input  logic             reg_we_i,
    input  logic [AW-1:0]    reg_addr_i,
    input  logic [7:0]       reg_wdata_i,
    output logic [7:0]       reg_rdata_o,
    input  logic             boundary_i,
    input  logic             ei_i,
    input  logic             di_i,
    input  logic             iret_i,
    input  logic [SPW-1:0]   sp_i,
    output logic             take_o,
    output logic [IDW-1:0]   src_o,
    output logic [SPW-1:0]   vector_o,
    output logic [SPW-1:0]   sp_entry_o,
    output logic [SPW-1:0]   sp_return_o
);
    icu_state_t st_q, st_d;

    logic [SRC_N-1:0] rise;
    logic [SRC_N-1:0] sel_oh;
    logic             any_pend;
    logic             wr_req;

    icu_edge #(.N(SRC_N)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (irq_i),
        .rise_o(rise)
    );

    icu_prio #(.N(SRC_N), .IDW(IDW)) u_prio (
        .pend_i  (st_q.req & st_q.en),
        .any_o   (any_pend),
        .sel_oh_o(sel_oh),
        .idx_o   (src_o)
    );

    assign take_o      = boundary_i & st_q.gie & any_pend;
    assign vector_o    = SPW'(src_o) << 1;
    assign sp_entry_o  = sp_i - SPW'(FRAME_B);
    assign sp_return_o = sp_i + SPW'(FRAME_B);
    assign wr_req      = reg_we_i & ((reg_addr_i == A_REQ_LO) | (reg_addr_i == A_REQ_HI));

    always_comb begin
        unique case (reg_addr_i)
            A_REQ_LO: reg_rdata_o = {1'b0, st_q.req[LO_N-1:0]};
            A_MSK_LO: reg_rdata_o = {st_q.gie, st_q.en[LO_N-1:0]};
            A_REQ_HI: reg_rdata_o = st_q.req[SRC_N-1:LO_N];
            A_MSK_HI: reg_rdata_o = st_q.en[SRC_N-1:LO_N];
            default:  reg_rdata_o = 8'h00;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (reg_we_i) begin
            if (reg_addr_i == A_REQ_LO) st_d.req[LO_N-1:0]     = reg_wdata_i[LO_N-1:0];
            if (reg_addr_i == A_REQ_HI) st_d.req[SRC_N-1:LO_N] = reg_wdata_i;
            if (reg_addr_i == A_MSK_LO) {st_d.gie, st_d.en[LO_N-1:0]} = reg_wdata_i;
            if (reg_addr_i == A_MSK_HI) st_d.en[SRC_N-1:LO_N]  = reg_wdata_i;
        end
        if (ei_i || iret_i) st_d.gie = 1'b1;
        if (di_i)           st_d.gie = 1'b0;
        if (take_o) begin
            st_d.gie = 1'b0;
            st_d.req = st_d.req & ~sel_oh;
        end
        st_d.req = st_d.req | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Assertions
    p_sel_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_oh));

    p_take_has_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ((st_q.req & st_q.en & sel_oh) != '0));

    p_edge_latched_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((st_q.req & $past(rise)) == $past(rise)));

    p_take_drops_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !st_q.gie);

    p_take_drops_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !wr_req && ((rise & sel_oh) == '0)) |=> ((st_q.req & $past(sel_oh)) == '0));

    p_iret_sets_gie_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (iret_i && !take_o && !di_i) |=> st_q.gie);

    p_di_clears_gie_r8: assert property (@(posedge clk) disable iff (!rst_n)
        di_i |=> !st_q.gie);
endmodule

// File: tb/tb_irq_vector_ctl.sv
module tb_irq_vector_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] irq_i = '0;
    logic        reg_we_i = 1'b0;
    logic [7:0]  reg_addr_i = 8'h00;
    logic [7:0]  reg_wdata_i = 8'h00;
    logic [7:0]  reg_rdata_o;
    logic        boundary_i = 1'b0, ei_i = 1'b0, di_i = 1'b0, iret_i = 1'b0;
    logic [15:0] sp_i = 16'h0000;
    logic        take_o;
    logic [3:0]  src_o;
    logic [15:0] vector_o, sp_entry_o, sp_return_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_vector_ctl dut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .reg_we_i(reg_we_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .boundary_i(boundary_i), .ei_i(ei_i), .di_i(di_i), .iret_i(iret_i),
        .sp_i(sp_i), .take_o(take_o), .src_o(src_o), .vector_o(vector_o),
        .sp_entry_o(sp_entry_o), .sp_return_o(sp_return_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_we_i = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        reg_addr_i = a;
        #2 check(req, {24'h0, reg_rdata_o}, {24'h0, exp});
    endtask

    task automatic pulse_irq(input int n);
        @(negedge clk); irq_i[n] = 1'b1;
        @(negedge clk); irq_i[n] = 1'b0;
    endtask

    task automatic op(input int which);
        @(negedge clk);
        ei_i = (which == 0); di_i = (which == 1); iret_i = (which == 2);
        @(negedge clk);
        ei_i = 1'b0; di_i = 1'b0; iret_i = 1'b0;
    endtask

    task automatic t_reset();
        irq_i[3] = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        rd_chk(8'hFA, 8'h00, "R1/R10 low pending after reset");
        rd_chk(8'hFB, 8'h00, "R1 low mask after reset");
        rd_chk(8'hF8, 8'h00, "R1 high pending after reset");
        rd_chk(8'hF9, 8'h00, "R1 high mask after reset");
        @(negedge clk); boundary_i = 1'b1;
        #2 check("R1 no take after reset", {31'h0, take_o}, 32'h0);
        boundary_i = 1'b0;
        @(negedge clk); irq_i[3] = 1'b0;
        @(negedge clk); irq_i[3] = 1'b1;
        @(negedge clk); irq_i[3] = 1'b0;
        rd_chk(8'hFA, 8'h08, "R10 new edge after reset latches");
        wr(8'hFA, 8'h00);
    endtask

    task automatic t_regmap();
        wr(8'hFB, 8'h85);
        rd_chk(8'hFB, 8'h85, "R2 low mask readback");
        wr(8'hFA, 8'hFF);
        rd_chk(8'hFA, 8'h7F, "R2 low pending bit7 reads 0");
        wr(8'hF9, 8'hA5);
        rd_chk(8'hF9, 8'hA5, "R2 high mask readback");
        wr(8'hF8, 8'h3C);
        rd_chk(8'hF8, 8'h3C, "R2 high pending readback");
        rd_chk(8'h10, 8'h00, "R2 unmapped reads 0");
        wr(8'hFA, 8'h00); wr(8'hF8, 8'h00); wr(8'hFB, 8'h00); wr(8'hF9, 8'h00);
    endtask

    task automatic t_edge();
        @(negedge clk); irq_i[9] = 1'b1;
        rd_chk(8'hF8, 8'h04, "R3 edge on source 9");
        wr(8'hF8, 8'h00);
        repeat (3) @(negedge clk);
        rd_chk(8'hF8, 8'h00, "R3 held level does not re-set");
        irq_i[9] = 1'b0;
    endtask

    task automatic t_write_collide();
        @(negedge clk);
        reg_we_i = 1'b1; reg_addr_i = 8'hFA; reg_wdata_i = 8'h01; irq_i[5] = 1'b1;
        @(negedge clk);
        reg_we_i = 1'b0; irq_i[5] = 1'b0;
        rd_chk(8'hFA, 8'h21, "R4 write plus same-cycle edge");
        wr(8'hFA, 8'h00);
        rd_chk(8'hFA, 8'h00, "R4 write clears pending");
    endtask

    task automatic t_service();
        wr(8'hFB, 8'h7F); wr(8'hF9, 8'hFF);
        pulse_irq(4); pulse_irq(12);
        @(negedge clk); boundary_i = 1'b1;
        #2 check("R5 no take with global enable off", {31'h0, take_o}, 32'h0);
        boundary_i = 1'b0;
        wr(8'hFB, 8'h6F);
        op(0);
        @(negedge clk); boundary_i = 1'b1;
        #2 check("R5 take when enabled pending", {31'h0, take_o}, 32'h1);
        check("R6 masked lower source skipped", {28'h0, src_o}, 32'd12);
        check("R6 vector of source 12", {16'h0, vector_o}, 32'h18);
        @(negedge clk); boundary_i = 1'b0;
        rd_chk(8'hF8, 8'h00, "R7 accepted source 12 cleared");
        rd_chk(8'hFB, 8'h6F, "R7 global enable cleared on take");
        pulse_irq(12);
        wr(8'hFB, 8'hFF);
        @(negedge clk); boundary_i = 1'b1;
        #2 check("R6 lowest source wins", {28'h0, src_o}, 32'd4);
        check("R6 vector of source 4", {16'h0, vector_o}, 32'h8);
        @(negedge clk); boundary_i = 1'b0;
        rd_chk(8'hFA, 8'h00, "R7 source 4 cleared");
        rd_chk(8'hF8, 8'h20, "R7 source 12 still pending");
        rd_chk(8'hFB, 8'h7F, "R7 global enable cleared again");
        wr(8'hF8, 8'h00);
    endtask

    task automatic t_gie();
        op(0);
        rd_chk(8'hFB, 8'hFF, "R8 enable-interrupt sets global");
        op(1);
        rd_chk(8'hFB, 8'h7F, "R8 disable-interrupt clears global");
        op(2);
        rd_chk(8'hFB, 8'hFF, "R8 return sets global");
        pulse_irq(2);
        @(negedge clk); boundary_i = 1'b1; ei_i = 1'b1;
        #2 check("R8 take with same-cycle enable", {31'h0, take_o}, 32'h1);
        @(negedge clk); boundary_i = 1'b0; ei_i = 1'b0;
        rd_chk(8'hFB, 8'h7F, "R8 take overrides enable");
    endtask

    task automatic t_sp();
        @(negedge clk); sp_i = 16'h0100;
        #2 check("R9 entry sp", {16'h0, sp_entry_o}, 32'h00FD);
        check("R9 return sp", {16'h0, sp_return_o}, 32'h0103);
        @(negedge clk); sp_i = 16'h0001;
        #2 check("R9 entry sp wraps", {16'h0, sp_entry_o}, 32'hFFFE);
        @(negedge clk); sp_i = 16'hFFFE;
        #2 check("R9 return sp wraps", {16'h0, sp_return_o}, 32'h0001);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_regmap();
        t_edge();
        t_write_collide();
        t_service();
        t_gie();
        t_sp();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule